// File: doc/BRIEF.md
# Cascaded Euler Follower Oscillator Chain

This block is a digital chain of first-order leaky integrators, discretised with the forward Euler rule at step h = 1/8. An external master system supplies a one-bit drive, already sampled in step with the master's delay line. That drive feeds the first stage. Each later stage is fed by the one-bit sign output of the stage before it. On every sampling instant each stage's state decays by one eighth and gains plus or minus one quarter, depending on whether its incoming drive stands for +2 or −2. Each stage then thresholds its own state to produce the drive for the next stage.

The stages form a one-way cascade. Each stage follows its predecessor one delay later, so stage n reproduces the master's behaviour n delay-lengths ahead. The block exports only the sign bits of its stages. The states stay inside.

A clock-enable input marks the sampling instants, so the update rate can be divided down from the system clock. The chain length, the state width, the fraction width, the step shift and the threshold are all parameters.

Top module: `euler_slave_chain`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stage state becomes 0. Because 0 is not below the default threshold, every bit of `stage_sign` reads 1 after reset.
- R2: On a rising edge with `sample_en` high, each stage state x (signed, 16 bits, 12 fraction bits) becomes x − floor(x/8) + 1024 when its drive bit is 1, or x − floor(x/8) − 1024 when its drive bit is 0. The result saturates to the signed 16-bit range.
- R3: Stage 0 takes `drive_in` as its drive. Stage n (n ≥ 1) takes `stage_sign[n-1]` as it stood before the edge, so all stages update together from their old values.
- R4: `stage_sign[n]` is 1 exactly when stage n's state is at or above the threshold (default 0), and 0 otherwise. Bit value 1 encodes a drive of +2 and bit value 0 encodes −2.
- R5: On a rising edge with `sample_en` low, no state changes and `stage_sign` holds, whatever `drive_in` does.
- R6: A reset applied in the middle of operation returns the chain to the state of R1, even when `sample_en` is high at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | High on the clock cycles that are sampling instants |
| drive_in | input | 1 | Sampled master drive: 1 stands for +2, 0 for −2 |
| stage_sign | output | STAGES | Sign outputs of the stages, bit n belongs to stage n |

## Verification
The bench concentrates on the instants where a stage's state crosses zero. A design that used the new sign of a predecessor instead of the old one would flip a downstream stage one sample early. A design that rounded the one-eighth leak toward zero instead of toward minus infinity would drift by one LSB on negative states, and over long runs that drift moves the crossing sample. Gaps in `sample_en` with a toggling drive catch a design that updates on every clock. A reset raised while `sample_en` is high catches a reset that loses priority to the update.

// File: rtl/esc_pkg.sv
// Shared definitions for the Euler follower chain.
// Assumes: the one-bit drive encoding is common to all stages.
package esc_pkg;
    // Meaning of a one-bit drive or sign value
    typedef enum logic {
        DRV_NEG = 1'b0,   // stands for -2
        DRV_POS = 1'b1    // stands for +2
    } drive_e;
endpackage

// File: rtl/esc_update.sv
// Next-state arithmetic of one Euler stage:
//   nxt = sat(x - floor(x / 2^SHIFT) +/- 2^(FRAC+1-SHIFT))
// Assumes: x is signed two's complement with FRAC fraction bits.
// The arithmetic right shift gives the floor division by 2^SHIFT.
module esc_update #(
    parameter int W     = 16,
    parameter int FRAC  = 12,
    parameter int SHIFT = 3
) (
    input  logic signed [W-1:0] x,
    input  logic                drive,
    output logic signed [W-1:0] nxt
);
    localparam int EW = W + 2;
    localparam logic signed [EW-1:0] STEP_E = EW'(1) <<< (FRAC + 1 - SHIFT);
    localparam logic signed [EW-1:0] MAX_E  = EW'((2 ** (W - 1)) - 1);
    localparam logic signed [EW-1:0] MIN_E  = -MAX_E - EW'(1);

    logic signed [EW-1:0] x_e;
    logic signed [EW-1:0] leak_e;
    logic signed [EW-1:0] sum_e;

    // Leaky accumulation in a widened word, then clamp to W bits
    always_comb begin
        x_e    = EW'(x);
        leak_e = x_e >>> SHIFT;
        sum_e  = x_e - leak_e + (drive ? STEP_E : -STEP_E);
        if (sum_e > MAX_E)
            nxt = MAX_E[W-1:0];
        else if (sum_e < MIN_E)
            nxt = MIN_E[W-1:0];
        else
            nxt = sum_e[W-1:0];
    end
endmodule

// File: rtl/esc_threshold.sv
// Binary nonlinearity: 1 (+2) when the state is at or above THRESH, else 0 (-2).
// Assumes: THRESH fits the signed W-bit state range.
module esc_threshold #(
    parameter int W      = 16,
    parameter int THRESH = 0
) (
    input  logic signed [W-1:0] x,
    output logic                sign_o
);
    import esc_pkg::*;
    localparam logic signed [W-1:0] THR_W = W'(THRESH);

    drive_e lvl;

    // Compare the state against the threshold
    always_comb begin
        lvl    = (x >= THR_W) ? DRV_POS : DRV_NEG;
        sign_o = logic'(lvl);
    end
endmodule

// File: rtl/esc_stage.sv
// One follower stage: state register, Euler update and threshold.
// Assumes: synchronous active-low reset; the update happens only on sample_en.
module esc_stage #(
    parameter int W      = 16,
    parameter int FRAC   = 12,
    parameter int SHIFT  = 3,
    parameter int THRESH = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic drive,
    output logic sign_o
);
    localparam logic signed [W-1:0] BOUND_W = W'(2 ** (FRAC + 1));

    logic signed [W-1:0] x_q;
    logic signed [W-1:0] x_nxt;

    esc_update #(.W(W), .FRAC(FRAC), .SHIFT(SHIFT)) u_upd (
        .x     (x_q),
        .drive (drive),
        .nxt   (x_nxt)
    );

    esc_threshold #(.W(W), .THRESH(THRESH)) u_thr (
        .x      (x_q),
        .sign_o (sign_o)
    );

    // State register: cleared by reset, advanced on sampling instants
    always_ff @(posedge clk) begin
        if (!rst_n)
            x_q <= '0;
        else if (sample_en)
            x_q <= x_nxt;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> x_q == '0); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(x_q)); // R5
    AST_POS_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && drive) |=> (x_q >= $past(x_q))); // R2
    AST_NEG_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !drive) |=> (x_q <= $past(x_q))); // R2
    AST_STATE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (x_q <= BOUND_W) && (x_q >= -BOUND_W)); // R2
endmodule

// File: rtl/euler_slave_chain.sv
// Cascade of STAGES Euler follower stages. Stage 0 is driven by the sampled
// master drive; stage n by the sign of stage n-1. Only signs leave the block.
// Assumes: drive_in is already synchronous to clk and to the master delay line.
module euler_slave_chain #(
    parameter int STAGES = 3,
    parameter int W      = 16,
    parameter int FRAC   = 12,
    parameter int SHIFT  = 3,
    parameter int THRESH = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              drive_in,
    output logic [STAGES-1:0] stage_sign
);
    logic [STAGES:0] drv_link;

    // Entry of the cascade is the master drive
    always_comb drv_link[0] = drive_in;

    for (genvar n = 0; n < STAGES; n++) begin : g_stage
        esc_stage #(
            .W(W), .FRAC(FRAC), .SHIFT(SHIFT), .THRESH(THRESH)
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample_en (sample_en),
            .drive     (drv_link[n]),
            .sign_o    (drv_link[n+1])
        );
    end

    // Export the stage signs
    always_comb stage_sign = drv_link[STAGES:1];

    AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(stage_sign)); // R5
    AST_RESET_SIGNS: assert property (@(posedge clk)
        !rst_n |=> stage_sign == {STAGES{1'b1}}); // R6
endmodule

// File: tb/euler_slave_chain_bench.sv
module euler_slave_chain_bench;
    localparam int NST = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sample_en = 1'b0;
    logic           drive_in = 1'b0;
    logic [NST-1:0] stage_sign;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    int  mx[NST];
    logic [15:0] lfsr = 16'hACE1;

    euler_slave_chain u_euler_slave_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .drive_in   (drive_in),
        .stage_sign (stage_sign)
    );

    always #10 clk = ~clk;

    function automatic int floor8(input int v);
        int r;
        r = v % 8;
        if (r < 0) r += 8;
        return (v - r) / 8;
    endfunction

    function automatic logic [NST-1:0] model_signs();
        logic [NST-1:0] s;
        for (int i = 0; i < NST; i++) s[i] = (mx[i] >= 0);
        return s;
    endfunction

    task automatic check(input string tag, input logic [NST-1:0] exp);
        n_checks++;
        if (stage_sign !== exp) begin
            n_fail++;
            $display("FAIL %s: stage_sign=%b expected=%b", tag, stage_sign, exp);
        end
    endtask

    // One clock: drive inputs, advance the model at the edge, compare at negedge
    task automatic tick(input string tag, input bit rst, input bit en, input bit d);
        logic [NST-1:0] old;
        rst_n = ~rst; sample_en = en; drive_in = d;
        @(posedge clk);
        old = model_signs();
        if (rst) begin
            for (int i = 0; i < NST; i++) mx[i] = 0;
        end else if (en) begin
            for (int i = 0; i < NST; i++) begin
                int v;
                bit dv;
                dv = (i == 0) ? d : old[i-1];
                v = mx[i] - floor8(mx[i]) + (dv ? 1024 : -1024);
                if (v > 32767) v = 32767;
                if (v < -32768) v = -32768;
                mx[i] = v;
            end
        end
        @(negedge clk);
        check(tag, model_signs());
    endtask

    initial begin
        logic [NST-1:0] held;
        for (int i = 0; i < NST; i++) mx[i] = 0;
        tick("R1 reset", 1, 0, 0);
        tick("R1 reset", 1, 1, 1);
        check("R1 all ones after reset", 3'b111);
        // First update from zero: stage0 -> -1024 (0), later stages see old 1 -> +1024 (1)
        tick("R3 first step", 0, 1, 0);
        check("R4 first step signs", 3'b110);
        for (int k = 0; k < 40; k++) tick("R2 const low drive", 0, 1, 0);
        for (int k = 0; k < 40; k++) tick("R2 const high drive", 0, 1, 1);
        for (int k = 0; k < 60; k++) tick("R3 alternating", 0, 1, k[0]);
        for (int k = 0; k < 60; k++) tick("R3 slow square", 0, 1, k[3]);
        // Sample-enable gaps with a toggling drive
        for (int k = 0; k < 40; k++) begin
            held = stage_sign;
            tick("R5 idle", 0, 0, k[0]);
            check("R5 hold", held);
            tick("R5 step", 0, 1, k[2]);
        end
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick("R2 random drive", 0, lfsr[3], lfsr[0]);
        end
        for (int k = 0; k < 20; k++) tick("R4 drive low", 0, 1, 0);
        tick("R6 mid reset", 1, 1, 0);
        check("R6 all ones", 3'b111);
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick("R3 random after reset", 0, 1, lfsr[1]);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: done=%0b expected=1", done);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule